// File: doc/BRIEF.md
# Keyboard Scan-Code Queue with Prefix Folding

This block sits behind a PS/2 receiver that already turns the serial line into whole bytes. Each byte arrives with a one-cycle valid strobe. The block buffers the key codes until a consumer asks for them. The two prefix bytes a keyboard sends are not buffered as entries of their own:

- 0xE0 marks an extended key.
- 0xF0 marks a key release.

Instead, each prefix sets a pending mark. The marks are attached to the next ordinary byte, and the code and both marks go into the queue together as one entry.

The consumer pulses a pop request. On the clock edge that samples the request, a registered response is loaded with one of two results:

- the oldest code with its extended and release flags, or
- when nothing is buffered, an empty indication with a zero code.

The response holds its value until the next pop. When the queue is full, newly completed codes are discarded and a sticky overflow error is raised. The error stays set until the consumer clears it with a pulse.

Top module: `kbd_code_queue`

## Requirements
- R1: While `rst` is high, and on the first edge after it, the response shows `rsp_empty`=1, `rsp_code`=0x00, `rsp_ext`=0, `rsp_rel`=0, and `ovf_err`=0. The queue holds no entries and no prefix mark is pending.
- R2: A pop sampled while the queue holds entries loads the response with the oldest entry, with `rsp_empty`=0. Entries come out in arrival order.
- R3: A pop sampled while the queue is empty loads `rsp_empty`=1, `rsp_code`=0x00, `rsp_ext`=0 and `rsp_rel`=0.
- R4: A valid byte 0xE0 is not stored as an entry. It sets `rsp_ext`=1 on the next non-prefix byte stored.
- R5: A valid byte 0xF0 is not stored as an entry. It sets `rsp_rel`=1 on the next non-prefix byte stored. A code with no 0xF0 before it has `rsp_rel`=0.
- R6: 0xE0 followed by 0xF0 and then a code yields a single entry with both flags set.
- R7: Both pending marks clear once a non-prefix byte completes a code, whether that code is stored or dropped. The following code carries no flags unless it has prefixes of its own.
- R8: The queue holds up to DEPTH entries (DEPTH defaults to 16). A code completed while the queue is full is discarded and sets `ovf_err`. Fullness is judged before any pop in the same cycle.
- R9: `ovf_err` stays set until a cycle with `ovf_clr` high. If a drop occurs in that same cycle, the drop wins and the bit stays set.
- R10: Without a pop request, the response outputs hold their values.
- R11: Bytes presented with `in_valid` low have no effect on the queue or on the prefix marks.
- R12: A push and a pop in the same cycle both take effect. The pop returns the entry that was already at the head, or the empty result if the queue was empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe from the receiver |
| in_byte | input | 8 | Received scan-code byte |
| pop | input | 1 | Request for the next key entry |
| ovf_clr | input | 1 | Clears the sticky overflow error |
| rsp_code | output | 8 | Code of the last pop result |
| rsp_empty | output | 1 | Last pop found no entry |
| rsp_ext | output | 1 | Last popped code had the extended prefix |
| rsp_rel | output | 1 | Last popped code was a release |
| ovf_err | output | 1 | Sticky overflow error |

## Verification
The hardest situation to reach from the ports is a prefixed code that arrives at a full queue. Seeing it requires filling every slot, sending 0xE0 and a code so that they are discarded, and then freeing space. A following plain code must then come out without the extended flag, proving that the discarded code still cleared the pending mark. The bench fills the queue with sixteen distinct codes and forces the drop, and it checks `ovf_err` across the whole drain before clearing it. The corner where a push and a pop land in the same cycle is reached by raising both strobes on one edge, once with the queue empty and once with it non-empty.

// File: rtl/kbdq_pkg.sv
package kbdq_pkg;

    localparam int unsigned CODE_W = 8;

    localparam logic [CODE_W-1:0] EXT_PREFIX = 8'hE0;
    localparam logic [CODE_W-1:0] REL_PREFIX = 8'hF0;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              ext;
        logic              rel;
    } key_entry_t;

    typedef enum logic [1:0] {
        BYTE_CODE = 2'd0,
        BYTE_EXT  = 2'd1,
        BYTE_REL  = 2'd2
    } byte_kind_t;

    localparam key_entry_t NULL_ENTRY = '{code: '0, ext: 1'b0, rel: 1'b0};

    function automatic byte_kind_t classify(input logic [CODE_W-1:0] b);
        if (b == EXT_PREFIX) begin
            return BYTE_EXT;
        end
        if (b == REL_PREFIX) begin
            return BYTE_REL;
        end
        return BYTE_CODE;
    endfunction

endpackage

// File: rtl/kbdq_prefix.sv
module kbdq_prefix
    import kbdq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] in_byte,
    output logic              ent_valid,
    output key_entry_t        ent
);

    logic       ext_pend;
    logic       rel_pend;
    byte_kind_t kind;

    always_comb begin
        kind      = classify(in_byte);
        ent_valid = in_valid && (kind == BYTE_CODE);
        ent.code  = in_byte;
        ent.ext   = ext_pend;
        ent.rel   = rel_pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_pend <= 1'b0;
            rel_pend <= 1'b0;
        end else if (in_valid) begin
            unique case (kind)
                BYTE_EXT: ext_pend <= 1'b1;
                BYTE_REL: rel_pend <= 1'b1;
                default: begin
                    // a completed code consumes both marks, stored or not
                    ext_pend <= 1'b0;
                    rel_pend <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/kbdq_fifo.sv
module kbdq_fifo
    import kbdq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  key_entry_t       push_data,
    input  logic             pop,
    output key_entry_t       head,
    output logic             empty,
    output logic             drop,
    output logic [CNT_W-1:0] count
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    key_entry_t       slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             full;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (count == FULL_CNT);
        empty   = (count == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        drop    = push && full;
        head    = slots[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            slots[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/kbdq_resp.sv
module kbdq_resp
    import kbdq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pop,
    input  logic       src_empty,
    input  key_entry_t src_head,
    output key_entry_t rsp,
    output logic       rsp_empty
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp       <= NULL_ENTRY;
            rsp_empty <= 1'b1;
        end else if (pop) begin
            if (src_empty) begin
                rsp       <= NULL_ENTRY;
                rsp_empty <= 1'b1;
            end else begin
                rsp       <= src_head;
                rsp_empty <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/kbdq_checker.sv
module kbdq_checker
    import kbdq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [CODE_W-1:0] in_byte,
    input logic              pop,
    input logic              ovf_clr,
    input logic [CODE_W-1:0] rsp_code,
    input logic              rsp_empty,
    input logic              rsp_ext,
    input logic              rsp_rel,
    input logic              ovf_err,
    input logic [CNT_W-1:0]  q_count
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic is_pfx;
    assign is_pfx = (in_byte == EXT_PREFIX) || (in_byte == REL_PREFIX);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (rsp_empty && rsp_code == '0 && !rsp_ext && !rsp_rel
                 && !ovf_err && q_count == '0));

    assert_pop_data_R2: assert property (@(posedge clk) disable iff (rst)
        (pop && q_count != '0) |=> !rsp_empty);

    assert_pop_empty_R3: assert property (@(posedge clk) disable iff (rst)
        (pop && q_count == '0) |=> (rsp_empty && rsp_code == '0 && !rsp_ext && !rsp_rel));

    assert_prefix_unstored_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_pfx && !pop) |=> $stable(q_count));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        q_count <= FULL_CNT);

    assert_full_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (q_count == FULL_CNT && in_valid && !is_pfx && !pop) |=> (q_count == FULL_CNT && ovf_err));

    assert_sticky_err_R9: assert property (@(posedge clk) disable iff (rst)
        (ovf_err && !ovf_clr) |=> ovf_err);

    assert_hold_resp_R10: assert property (@(posedge clk) disable iff (rst)
        !pop |=> ($stable(rsp_code) && $stable(rsp_empty) && $stable(rsp_ext) && $stable(rsp_rel)));

    assert_idle_input_R11: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !pop) |=> $stable(q_count));

endmodule

// File: rtl/kbd_code_queue.sv
module kbd_code_queue
    import kbdq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] in_byte,
    input  logic              pop,
    input  logic              ovf_clr,
    output logic [CODE_W-1:0] rsp_code,
    output logic              rsp_empty,
    output logic              rsp_ext,
    output logic              rsp_rel,
    output logic              ovf_err
);

    logic             ent_valid;
    key_entry_t       ent;
    key_entry_t       head;
    key_entry_t       rsp;
    logic             q_empty;
    logic             q_drop;
    logic [CNT_W-1:0] q_count;

    kbdq_prefix u_prefix (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .ent_valid (ent_valid),
        .ent       (ent)
    );

    kbdq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (ent_valid),
        .push_data (ent),
        .pop       (pop),
        .head      (head),
        .empty     (q_empty),
        .drop      (q_drop),
        .count     (q_count)
    );

    kbdq_resp u_resp (
        .clk       (clk),
        .rst       (rst),
        .pop       (pop),
        .src_empty (q_empty),
        .src_head  (head),
        .rsp       (rsp),
        .rsp_empty (rsp_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_err <= 1'b0;
        end else if (q_drop) begin
            ovf_err <= 1'b1;
        end else if (ovf_clr) begin
            ovf_err <= 1'b0;
        end
    end

    assign rsp_code = rsp.code;
    assign rsp_ext  = rsp.ext;
    assign rsp_rel  = rsp.rel;

endmodule

bind kbd_code_queue kbdq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .pop       (pop),
    .ovf_clr   (ovf_clr),
    .rsp_code  (rsp_code),
    .rsp_empty (rsp_empty),
    .rsp_ext   (rsp_ext),
    .rsp_rel   (rsp_rel),
    .ovf_err   (ovf_err),
    .q_count   (q_count)
);

// File: tb/kbd_code_queue_tb.sv
`timescale 1ns/1ps
module kbd_code_queue_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       pop = 1'b0;
    logic       ovf_clr = 1'b0;
    logic [7:0] rsp_code;
    logic       rsp_empty;
    logic       rsp_ext;
    logic       rsp_rel;
    logic       ovf_err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    kbd_code_queue u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .pop       (pop),
        .ovf_clr   (ovf_clr),
        .rsp_code  (rsp_code),
        .rsp_empty (rsp_empty),
        .rsp_ext   (rsp_ext),
        .rsp_rel   (rsp_rel),
        .ovf_err   (ovf_err)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_rsp(input string tag, input logic [7:0] code,
                             input logic emp, input logic ext, input logic rel);
        chk({tag, " code"}, rsp_code, code);
        chk({tag, " empty"}, {7'd0, rsp_empty}, {7'd0, emp});
        chk({tag, " ext"}, {7'd0, rsp_ext}, {7'd0, ext});
        chk({tag, " rel"}, {7'd0, rsp_rel}, {7'd0, rel});
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pop_expect(input string tag, input logic [7:0] code,
                              input logic emp, input logic ext, input logic rel);
        @(negedge clk);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        check_rsp(tag, code, emp, ext, rel);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check_rsp("R1 reset", 8'h00, 1'b1, 1'b0, 1'b0);
        chk("R1 ovf_err", {7'd0, ovf_err}, 8'h00);
        pop_expect("R3 empty pop", 8'h00, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_plain;
        send(8'h1C); send(8'h32); send(8'h21);
        pop_expect("R2 first", 8'h1C, 1'b0, 1'b0, 1'b0);
        pop_expect("R2 second", 8'h32, 1'b0, 1'b0, 1'b0);
        pop_expect("R2 third", 8'h21, 1'b0, 1'b0, 1'b0);
        pop_expect("R3 drained", 8'h00, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_prefixes;
        send(8'hE0); send(8'h75);
        send(8'h75);
        send(8'hF0); send(8'h1C);
        send(8'h1C);
        send(8'hE0); send(8'hF0); send(8'h6B);
        send(8'h6B);
        pop_expect("R4 extended", 8'h75, 1'b0, 1'b1, 1'b0);
        pop_expect("R7 after ext", 8'h75, 1'b0, 1'b0, 1'b0);
        pop_expect("R5 release", 8'h1C, 1'b0, 1'b0, 1'b1);
        pop_expect("R5 make", 8'h1C, 1'b0, 1'b0, 1'b0);
        pop_expect("R6 both", 8'h6B, 1'b0, 1'b1, 1'b1);
        pop_expect("R7 after both", 8'h6B, 1'b0, 1'b0, 1'b0);
        pop_expect("R4 prefixes not stored", 8'h00, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_idle_and_hold;
        send(8'h29);
        pop_expect("R10 setup", 8'h29, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        in_byte = 8'hE0;
        repeat (3) @(negedge clk);
        in_byte = 8'h5A;
        repeat (3) @(negedge clk);
        check_rsp("R10 hold", 8'h29, 1'b0, 1'b0, 1'b0);
        pop_expect("R11 nothing stored", 8'h00, 1'b1, 1'b0, 1'b0);
        send(8'h2B);
        pop_expect("R11 no stray prefix", 8'h2B, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_overflow;
        for (int i = 0; i < 16; i++) send(8'h10 + 8'(i));
        chk("R8 no error when exactly full", {7'd0, ovf_err}, 8'h00);
        send(8'hE0); send(8'h55);
        chk("R8 drop raises error", {7'd0, ovf_err}, 8'h01);
        pop_expect("R8 head kept", 8'h10, 1'b0, 1'b0, 1'b0);
        send(8'h66);
        for (int i = 1; i < 16; i++)
            pop_expect("R8 order kept", 8'h10 + 8'(i), 1'b0, 1'b0, 1'b0);
        pop_expect("R7 dropped code cleared prefix", 8'h66, 1'b0, 1'b0, 1'b0);
        pop_expect("R8 dropped code absent", 8'h00, 1'b1, 1'b0, 1'b0);
        chk("R9 sticky", {7'd0, ovf_err}, 8'h01);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        chk("R9 cleared", {7'd0, ovf_err}, 8'h00);
    endtask

    task automatic t_simultaneous;
        @(negedge clk);
        in_valid = 1'b1; in_byte = 8'h3A; pop = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; pop = 1'b0;
        check_rsp("R12 empty pop with push", 8'h00, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        in_valid = 1'b1; in_byte = 8'h3B; pop = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; pop = 1'b0;
        check_rsp("R12 head with push", 8'h3A, 1'b0, 1'b0, 1'b0);
        pop_expect("R12 pushed entry", 8'h3B, 1'b0, 1'b0, 1'b0);
        pop_expect("R12 drained", 8'h00, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_plain();
        t_prefixes();
        t_idle_and_hold();
        t_overflow();
        t_simultaneous();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule